// File: doc/BRIEF.md
# Open-Loop LUT Training Sequencer

This controller fills a predistortion lookup table in a single open-loop pass. On a start request it first steers the amplifier output to a dummy load. It then presents every table address code, in turn, as a training symbol to the DAC path. After each code change it waits a programmable number of settle cycles. It then gathers a fixed power-of-two number of captured I/Q samples from the downconversion path, averages them per channel with rounding and saturation, and writes the averaged pair into the table entry addressed by that same code.

No loop is ever closed and no adaptive update runs: each entry is simply the averaged measured response to its own code. When the last code has been written, the load select returns to the antenna and a one-cycle done pulse follows. A new start request after completion runs the whole pass again, so the table can follow drift in temperature or supply. Analog capture, phase alignment and the modulator that later reads the table are outside this block.

Captured samples enter on a valid/ready stream. Ready is high only while the sequencer is gathering samples for the current code, and the source must hold its sample until it is taken. Table writes leave on a valid/ready stream. The sequencer holds address and data unchanged while the table side keeps ready low, and it does not move to the next code until the write has been accepted.

Top module: `lut_train_seq`

## Requirements
- R1: After reset, load_sel_o, busy_o, done_o, sym_valid_o, cap_ready_o and wr_valid_o are all 0.
- R2: A start_i pulse seen while idle sets load_sel_o (1 = dummy load) on the next cycle with sym_valid_o still 0. On the cycle after that, sym_valid_o is 1 with sym_code_o = 0. load_sel_o stays 1 whenever sym_valid_o is 1.
- R3: Codes 0 to 2^CODE_W-1 are presented once each in ascending order. There is exactly one table write per code, with wr_addr_o equal to that code.
- R4: settle_cycles_i is latched at start. Each new code is held with cap_ready_o low for exactly settle+1 cycles before cap_ready_o rises. Later changes of settle_cycles_i do not affect the running pass.
- R5: A sample is taken only on a cycle with cap_valid_i and cap_ready_o both 1. Exactly 2^AVG_LOG2 samples are taken per code, and the accumulated sums do not change on other cycles.
- R6: Each written channel value is floor((sum + 2^(AVG_LOG2-1)) / 2^AVG_LOG2), where sum is the two's-complement sum of that channel's samples. The in-phase channel goes to wr_re_o and the quadrature channel to wr_im_o.
- R7: A rounded average outside the signed OUT_W range is clipped to -2^(OUT_W-1) or 2^(OUT_W-1)-1.
- R8: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o, wr_addr_o, wr_re_o and wr_im_o hold their values on the next cycle.
- R9: After the last write, load_sel_o falls to 0. done_o is then 1 for exactly one cycle, starting the cycle after load_sel_o falls, and busy_o is 0 on the cycle after done_o.
- R10: start_i while busy_o is 1 is ignored: the code sequence continues without restart and the pass produces no extra writes.
- R11: A start after completion runs a full new pass, using newly captured samples and the newly latched settle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a training pass (used only while idle) |
| settle_cycles_i | input | SETTLE_W | Settle wait per code, latched at start |
| load_sel_o | output | 1 | 1 routes amplifier to the dummy load, 0 to the antenna |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sym_valid_o | output | 1 | sym_code_o is an active training symbol |
| sym_code_o | output | CODE_W | Training symbol: the table address code being measured |
| cap_valid_i | input | 1 | Captured sample pair is valid |
| cap_ready_o | output | 1 | Sequencer accepts a captured sample |
| cap_re_i | input | SAMPLE_W | Captured in-phase sample, signed |
| cap_im_i | input | SAMPLE_W | Captured quadrature sample, signed |
| wr_valid_o | output | 1 | Table write request |
| wr_ready_i | input | 1 | Table accepts the write |
| wr_addr_o | output | CODE_W | Table entry address |
| wr_re_o | output | OUT_W | Averaged in-phase value, signed |
| wr_im_o | output | OUT_W | Averaged quadrature value, signed |

## Verification
The bench builds the sequencer with CODE_W=4, AVG_LOG2=3, SAMPLE_W=13, OUT_W=12 and SETTLE_W=6. Sixteen codes averaged over eight samples keep two full passes short, and the wider sample range lets the extreme codes average beyond the 12-bit table range, so both clipping bounds are reached. The sample source gaps its valid line and the table side stalls its ready line in a fixed rhythm, so capture gaps and write back-pressure happen on many codes. One pass settles for three cycles and the second for zero cycles, which covers the shortest settle window and a re-trigger with a different latched value.

// File: rtl/lut_train_pkg.sv
package lut_train_pkg;

  // Sequencer states, in the order a pass visits them.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SWITCH  = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_ACCUM   = 3'd3,
    ST_WRITE   = 3'd4,
    ST_NEXT    = 3'd5,
    ST_RELEASE = 3'd6,
    ST_DONE    = 3'd7
  } seq_state_t;

  // Number of I/Q channels carried through the capture path.
  localparam int NUM_CH = 2;

endpackage

// File: rtl/lut_train_fsm.sv
module lut_train_fsm
  import lut_train_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int AVG_LOG2 = 5,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cap_valid_i,
  input  logic                wr_ready_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                take_o,
  output logic                clear_o,
  output logic                cap_ready_o,
  output logic                wr_valid_o,
  output logic                load_sel_o,
  output logic                sym_valid_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam logic [CODE_W-1:0]   CODE_LAST = '1;
  localparam logic [AVG_LOG2-1:0] SMP_LAST  = '1;

  seq_state_t            state_q;
  logic [CODE_W-1:0]     code_q;
  logic [SETTLE_W-1:0]   settle_q;
  logic [SETTLE_W-1:0]   wait_q;
  logic [AVG_LOG2-1:0]   nsmp_q;

  // Output decode: every control output is a function of the state only.
  always_comb begin
    load_sel_o  = 1'b0;
    sym_valid_o = 1'b0;
    cap_ready_o = 1'b0;
    wr_valid_o  = 1'b0;
    clear_o     = 1'b0;
    done_o      = 1'b0;
    busy_o      = (state_q != ST_IDLE);
    unique case (state_q)
      ST_IDLE:    ;
      ST_SWITCH:  load_sel_o = 1'b1;
      ST_SETTLE: begin
        load_sel_o  = 1'b1;
        sym_valid_o = 1'b1;
        clear_o     = 1'b1;
      end
      ST_ACCUM: begin
        load_sel_o  = 1'b1;
        sym_valid_o = 1'b1;
        cap_ready_o = 1'b1;
      end
      ST_WRITE: begin
        load_sel_o  = 1'b1;
        sym_valid_o = 1'b1;
        wr_valid_o  = 1'b1;
      end
      ST_NEXT: begin
        load_sel_o  = 1'b1;
        sym_valid_o = 1'b1;
      end
      ST_RELEASE: ;
      ST_DONE:    done_o = 1'b1;
      default:    ;
    endcase
  end

  assign take_o = cap_valid_i & cap_ready_o;
  assign code_o = code_q;

  // Sequencing: switch, then settle / accumulate / write per code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      settle_q <= '0;
      wait_q   <= '0;
      nsmp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_SWITCH;
            settle_q <= settle_cycles_i;
            code_q   <= '0;
          end
        end
        ST_SWITCH: begin
          state_q <= ST_SETTLE;
          wait_q  <= settle_q;
        end
        ST_SETTLE: begin
          if (wait_q == '0) begin
            state_q <= ST_ACCUM;
            nsmp_q  <= '0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_ACCUM: begin
          if (take_o) begin
            if (nsmp_q == SMP_LAST) state_q <= ST_WRITE;
            else                    nsmp_q  <= nsmp_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (wr_ready_i) state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (code_q == CODE_LAST) begin
            state_q <= ST_RELEASE;
          end else begin
            code_q  <= code_q + 1'b1;
            wait_q  <= settle_q;
            state_q <= ST_SETTLE;
          end
        end
        ST_RELEASE: state_q <= ST_DONE;
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker counter: settle cycles spent since the symbol last changed.
  logic [SETTLE_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      gap_q <= '0;
    else if (state_q == ST_SWITCH || state_q == ST_NEXT) gap_q <= '0;
    else if (state_q == ST_SETTLE && gap_q != '1)    gap_q <= gap_q + 1'b1;
  end

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready_o |-> (gap_q > {1'b0, settle_q})) else $error("settle window cut short"); // R4

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEXT && code_q != CODE_LAST) |=>
      (code_q == $past(code_q) + 1'b1) && (state_q == ST_SETTLE)) else $error("code step"); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && state_q != ST_NEXT) |=> ($stable(code_o) && state_q != ST_SWITCH))
    else $error("start honoured while busy"); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!load_sel_o && !$past(load_sel_o))) else $error("done before antenna"); // R9

endmodule

// File: rtl/lut_train_accum.sv
module lut_train_accum #(
  parameter int SAMPLE_W = 12,
  parameter int AVG_LOG2 = 5,
  localparam int SUM_W   = SAMPLE_W + AVG_LOG2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       take_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SUM_W-1:0]    sum_o
);

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sample_ext;

  // Sign-extend so 2^AVG_LOG2 full-scale samples cannot overflow.
  assign sample_ext = {{AVG_LOG2{sample_i[SAMPLE_W-1]}}, sample_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (take_i) sum_q <= sum_q + sample_ext;
  end

  assign sum_o = sum_q;

  AST_SUM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !clr_i) |=> $stable(sum_o)) else $error("sum moved without a sample"); // R5

endmodule

// File: rtl/lut_train_avg.sv
module lut_train_avg #(
  parameter int SUM_W    = 17,
  parameter int AVG_LOG2 = 5,
  parameter int OUT_W    = 12
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [OUT_W-1:0] avg_o
);

  localparam int EXT_W = SUM_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) << (AVG_LOG2 - 1);
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] quot;

  // Round half up, then floor-divide by an arithmetic shift.
  always_comb begin
    ext    = {sum_i[SUM_W-1], sum_i};
    biased = ext + HALF;
    quot   = biased >>> AVG_LOG2;
    if (quot > MAXV)      avg_o = MAXV[OUT_W-1:0];
    else if (quot < MINV) avg_o = MINV[OUT_W-1:0];
    else                  avg_o = quot[OUT_W-1:0];
  end

endmodule

// File: rtl/lut_train_seq.sv
module lut_train_seq
  import lut_train_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int AVG_LOG2 = 5,
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 12,
  parameter int SETTLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [SETTLE_W-1:0]        settle_cycles_i,
  output logic                       load_sel_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       sym_valid_o,
  output logic [CODE_W-1:0]          sym_code_o,
  input  logic                       cap_valid_i,
  output logic                       cap_ready_o,
  input  logic signed [SAMPLE_W-1:0] cap_re_i,
  input  logic signed [SAMPLE_W-1:0] cap_im_i,
  output logic                       wr_valid_o,
  input  logic                       wr_ready_i,
  output logic [CODE_W-1:0]          wr_addr_o,
  output logic signed [OUT_W-1:0]    wr_re_o,
  output logic signed [OUT_W-1:0]    wr_im_o
);

  localparam int SUM_W = SAMPLE_W + AVG_LOG2;

  logic              take;
  logic              clear;
  logic [CODE_W-1:0] code;

  logic signed [SAMPLE_W-1:0] smp   [NUM_CH];
  logic signed [SUM_W-1:0]    sum_w [NUM_CH];
  logic signed [OUT_W-1:0]    avg_w [NUM_CH];

  assign smp[0] = cap_re_i;
  assign smp[1] = cap_im_i;

  lut_train_fsm #(
    .CODE_W   (CODE_W),
    .AVG_LOG2 (AVG_LOG2),
    .SETTLE_W (SETTLE_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .settle_cycles_i (settle_cycles_i),
    .cap_valid_i     (cap_valid_i),
    .wr_ready_i      (wr_ready_i),
    .code_o          (code),
    .take_o          (take),
    .clear_o         (clear),
    .cap_ready_o     (cap_ready_o),
    .wr_valid_o      (wr_valid_o),
    .load_sel_o      (load_sel_o),
    .sym_valid_o     (sym_valid_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
  );

  // One accumulator and one averager per capture channel.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    lut_train_accum #(
      .SAMPLE_W (SAMPLE_W),
      .AVG_LOG2 (AVG_LOG2)
    ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clear),
      .take_i   (take),
      .sample_i (smp[ch]),
      .sum_o    (sum_w[ch])
    );

    lut_train_avg #(
      .SUM_W    (SUM_W),
      .AVG_LOG2 (AVG_LOG2),
      .OUT_W    (OUT_W)
    ) u_avg (
      .sum_i (sum_w[ch]),
      .avg_o (avg_w[ch])
    );

    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !sum_w[ch][SUM_W-1]) |-> !avg_w[ch][OUT_W-1])
      else $error("clipping flipped sign"); // R7
  end

  assign sym_code_o = code;
  assign wr_addr_o  = code;
  assign wr_re_o    = avg_w[0];
  assign wr_im_o    = avg_w[1];

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_re_o) && $stable(wr_im_o)))
    else $error("write dropped under back-pressure"); // R8

  AST_LOAD_DURING_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> load_sel_o) else $error("symbol sent toward antenna"); // R2

endmodule

// File: tb/lut_train_seq_test.sv
module lut_train_seq_test;

  localparam int CW = 4, AL = 3, SW = 13, OW = 12, STW = 6;
  localparam int NCODE = 1 << CW, NSMP = 1 << AL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, load_sel, busy, done, sym_valid, cap_valid, cap_ready;
  logic wr_valid, wr_ready;
  logic [STW-1:0] settle_in;
  logic [CW-1:0] sym_code, wr_addr;
  logic signed [SW-1:0] cap_re, cap_im;
  logic signed [OW-1:0] wr_re, wr_im;

  lut_train_seq #(.CODE_W(CW), .AVG_LOG2(AL), .SAMPLE_W(SW), .OUT_W(OW), .SETTLE_W(STW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_cycles_i(settle_in),
    .load_sel_o(load_sel), .busy_o(busy), .done_o(done),
    .sym_valid_o(sym_valid), .sym_code_o(sym_code),
    .cap_valid_i(cap_valid), .cap_ready_o(cap_ready), .cap_re_i(cap_re), .cap_im_i(cap_im),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_re_o(wr_re), .wr_im_o(wr_im));

  int total = 0, bad = 0;
  int run_id = 0, settle_cur = 0, done_cnt = 0, wr_cnt = 0;

  typedef struct { int addr; int re; int im; } wr_item_t;
  wr_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int gen_re(input int run, input int c, input int k);
    return (c - 8) * 500 + k * 13 - 40 + run * 7;
  endfunction

  function automatic int gen_im(input int run, input int c, input int k);
    return (8 - c) * 250 + k * k * 5 - run * 11;
  endfunction

  // R6 rounding rule and R7 clipping, computed from the requirement text.
  function automatic int exp_avg(input int s);
    int r;
    r = (s + (NSMP / 2)) >>> AL;
    if (r > (1 << (OW - 1)) - 1) r = (1 << (OW - 1)) - 1;
    if (r < -(1 << (OW - 1)))    r = -(1 << (OW - 1));
    return r;
  endfunction

  task automatic push_expected(input int run);
    for (int c = 0; c < NCODE; c++) begin
      int sr = 0, si = 0;
      wr_item_t it;
      for (int k = 0; k < NSMP; k++) begin
        sr += gen_re(run, c, k);
        si += gen_im(run, c, k);
      end
      it.addr = c; it.re = exp_avg(sr); it.im = exp_avg(si);
      exp_q.push_back(it);
    end
  endtask

  // Monitor and stream source: one process, runs at the falling edge.
  initial begin
    bit p_ready = 0, p_wv = 0, p_load = 0, p_sv = 0, p_done = 0, seen = 0;
    int p_addr = 0, p_re = 0, p_im = 0, p_code = 0, k = 0, gap = 0, cyc = 0;
    cap_valid = 0; wr_ready = 0; cap_re = '0; cap_im = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ready && cap_valid) k++;
        if (p_wv && wr_ready) begin
          wr_cnt++;
          if (exp_q.size() == 0) begin
            check(0, "R3", "unexpected write addr", p_addr, -1);
          end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            check(p_addr == e.addr, "R3", "write addr", p_addr, e.addr);
            check(p_re == e.re, "R6/R7", "re value", p_re, e.re);
            check(p_im == e.im, "R6/R7", "im value", p_im, e.im);
            check(k == NSMP, "R5", "samples per code", k, NSMP);
          end
          k = 0;
        end
        if (p_wv && !wr_ready) begin
          check(wr_valid == 1'b1, "R8", "valid held", int'(wr_valid), 1);
          check(int'(wr_addr) == p_addr && int'(wr_re) == p_re && int'(wr_im) == p_im,
                "R8", "write held addr", int'(wr_addr), p_addr);
        end
        if (sym_valid && (!p_sv || int'(sym_code) != p_code)) begin
          gap = 0; seen = 0;
        end
        if (sym_valid && !seen) begin
          if (cap_ready) begin
            check(gap == settle_cur + 1, "R4", "settle cycles", gap, settle_cur + 1);
            seen = 1;
          end else gap++;
        end
        if (sym_valid) check(load_sel == 1'b1, "R2", "load while symbol", int'(load_sel), 1);
        if (done) begin
          done_cnt++;
          check(!p_load && !load_sel, "R9", "antenna before done", int'(p_load), 0);
          check(exp_q.size() == 0, "R3", "entries left at done", exp_q.size(), 0);
        end
        if (p_done) check(!done && !busy, "R9", "done width / busy", int'(done), 0);
      end
      cyc++;
      cap_valid = (cyc % 3) != 1;
      wr_ready  = ((cyc % 5) != 0) && ((cyc % 23) > 2);
      cap_re = SW'(gen_re(run_id, int'(sym_code), k));
      cap_im = SW'(gen_im(run_id, int'(sym_code), k));
      p_ready = cap_ready; p_wv = wr_valid; p_load = load_sel; p_sv = sym_valid;
      p_done = done; p_addr = int'(wr_addr); p_re = int'(wr_re); p_im = int'(wr_im);
      p_code = int'(sym_code);
    end
  end

  task automatic run_training(input int st, input int rid, input bit poke);
    run_id = rid; settle_cur = st;
    push_expected(rid);
    settle_in = STW'(st);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle_in = STW'(9);
    check(load_sel && !sym_valid, "R2", "switch before symbol", int'(load_sel), 1);
    @(negedge clk);
    check(sym_valid && sym_code == '0, "R2", "first code", int'(sym_code), 0);
    if (poke) begin
      while (sym_code != CW'(5)) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && load_sel, "R10", "busy after start in run", int'(busy), 1);
      check(int'(sym_code) >= 5, "R10", "code not restarted", int'(sym_code), 5);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!busy && !load_sel, "R9", "idle after done", int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; settle_in = '0;
    repeat (3) @(negedge clk);
    check(!load_sel && !busy && !done, "R1", "reset ctl", int'(load_sel), 0);
    check(!sym_valid && !cap_ready && !wr_valid, "R1", "reset streams", int'(wr_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !cap_ready && !wr_valid, "R1", "idle holds", int'(busy), 0);
    run_training(3, 0, 1'b1);
    check(done_cnt == 1 && wr_cnt == NCODE, "R10", "writes in poked pass", wr_cnt, NCODE);
    repeat (5) @(negedge clk);
    run_training(0, 1, 1'b0);
    check(done_cnt == 2, "R11", "second done", done_cnt, 2);
    check(wr_cnt == 2 * NCODE, "R11", "writes after re-trigger", wr_cnt, 2 * NCODE);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule